// File: doc/BRIEF.md
# External Bus Cycle Controller

This block runs single read and write transfers from an internal master to an external memory or peripheral. The internal master presents an address, a direction bit and write data. The controller then sequences the external pins: address, read/write strobe, one active-low chip select, an active-low output enable and a tri-state data bus, shown here as a drive-enable plus data.

The controller's clock runs at twice the bus clock rate. A phase bit splits each bus clock into a rising half (phase 0) and a falling half (phase 1), and the bus clock is brought out as `bclk_o`. One transfer steps through six half-clock phases, S0 to S5. S0, S2 and S4 fall on rising halves. S1, S3 and S5 fall on falling halves.

The acknowledge that ends the strobe comes from one of two places:
- an active-low pin, synchronised inside the block;
- an internal counter loaded from a 4-bit wait-state field, when auto-acknowledge is selected.

Each unacknowledged S3 sends the sequence back to S2, which adds one full bus clock. A one-clock done pulse returns the captured read data to the internal master.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is held and directly after it, `cs_n_o`=1, `oe_n_o`=1, `bus_en_o`=0, `data_oe_o`=0, `done_o`=0 and `rw_o`=1.
- R2: A request is taken only on a clock where `req_i` and `req_ready_o` are both high. `req_ready_o` is high only in a falling half (`bclk_o`=0) while idle or in S5. In the next clock (S0, a rising half), `bus_en_o`=1, `addr_o` carries the request address, `rw_o`=1 for a read (`req_we_i`=0) and `rw_o`=0 for a write (`req_we_i`=1), and `cs_n_o` is still 1.
- R3: `cs_n_o` goes low in S1 (a falling half) and returns high in S5 (a falling half). During a read, `oe_n_o` equals `cs_n_o`. During a write, `oe_n_o` stays 1.
- R4: With `auto_ack_i`=1 and `wait_states_i`=n, `cs_n_o` is low for exactly 4+2n controller clocks (2+n bus clocks).
- R5: With `auto_ack_i`=1, the level of `ta_n_i` has no effect on the cycle length.
- R6: With `auto_ack_i`=0, `ta_n_i` is registered once. The strobe ends at the first S3 whose closing edge sees the registered value low. If `ta_n_i` goes low during the K-th clock of chip-select low (K≥1), chip select stays low for s+1 clocks, where s is the smallest odd number that is at least max(3, K+1). If `ta_n_i` is low from before the request, chip select stays low for 4 clocks.
- R7: Read data is taken from `data_i` on the edge that closes the acknowledged S3. In the following clock (S4, the last chip-select-low clock), `done_o`=1 for exactly one clock and `rdata_o` holds that data.
- R8: In a write, `data_oe_o` is 0 in S0 and S1. It is 1 in every later chip-select-low clock, with `data_o` equal to the request's write data, and it drops together with chip select in S5. `done_o` also pulses once for a write.
- R9: A request taken in S5 starts S0 in the very next clock, so `bus_en_o` stays 1 and `addr_o` switches to the new address.
- R10: Without a new request, `bus_en_o` is 1 through S5 and falls to 0 in the following rising half. Each lone transfer keeps `bus_en_o` high for exactly 2 clocks more than its chip-select-low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transfer request from the internal master |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Transfer address |
| req_wdata_i | input | DW | Write data |
| wait_states_i | input | 4 | Extra bus clocks for auto-acknowledge |
| auto_ack_i | input | 1 | 1 = internal acknowledge, 0 = external pin |
| req_ready_o | output | 1 | A request is taken on this clock if `req_i`=1 |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DW | Captured read data |
| bclk_o | output | 1 | Bus clock (1 in rising half) |
| addr_o | output | AW | External address |
| bus_en_o | output | 1 | Address and R/W are being driven |
| rw_o | output | 1 | 1 = read, 0 = write |
| cs_n_o | output | 1 | Active-low chip select |
| oe_n_o | output | 1 | Active-low output enable |
| data_o | output | DW | Write data to the bus |
| data_oe_o | output | 1 | Data bus drive enable |
| data_i | input | DW | Read data from the bus |
| ta_n_i | input | 1 | Active-low external transfer acknowledge |

## Verification
The bench targets the acknowledge arithmetic.
- An off-by-one in the wait-state counter shows up as a chip-select window two clocks too long or too short.
- A missing synchroniser, or a check of the acknowledge in S2 instead of S3, makes the externally acknowledged window end one bus clock early or late against the odd-rounded formula.
- Letting the acknowledge pin through in auto mode shortens cycles whose pin is held low.

Writes that drive data in S0 or S1 are flagged by the per-clock drive check. So are writes that keep driving into S5. A controller that cannot restart from S5 drops `bus_en_o` between back-to-back transfers.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int WS_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S0   = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S3   = 3'd4,
        ST_S4   = 3'd5,
        ST_S5   = 3'd6
    } bus_state_e;

    // Chip select is low from S1 up to and including S4.
    function automatic logic strobe_on(bus_state_e s);
        return (s == ST_S1) || (s == ST_S2) || (s == ST_S3) || (s == ST_S4);
    endfunction

    // Write data is driven from S2 until chip select is released.
    function automatic logic wdrive_on(bus_state_e s);
        return (s == ST_S2) || (s == ST_S3) || (s == ST_S4);
    endfunction

endpackage

// File: rtl/ebc_phase_gen.sv
module ebc_phase_gen (
    input  logic clk,
    input  logic rst,
    output logic fall_half_o
);
    always_ff @(posedge clk) begin
        if (rst) fall_half_o <= 1'b0;
        else     fall_half_o <= ~fall_half_o;
    end
endmodule

// File: rtl/ebc_ack_unit.sv
module ebc_ack_unit #(
    parameter int WSW = ebc_pkg::WS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ta_n_i,
    input  logic           auto_en_i,
    input  logic [WSW-1:0] ws_i,
    input  logic           load_i,
    input  logic           step_i,
    output logic           ack_o
);
    logic           ta_q;
    logic [WSW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) ta_q <= 1'b1;
        else     ta_q <= ta_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst)                         remain_q <= '0;
        else if (load_i)                 remain_q <= ws_i;
        else if (step_i && remain_q != 0) remain_q <= remain_q - 1'b1;
    end

    assign ack_o = auto_en_i ? (remain_q == '0) : ~ta_q;
endmodule

// File: rtl/ebc_rd_capture.sv
module ebc_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire_i,
    input  logic [DW-1:0] bus_i,
    output logic          done_o,
    output logic [DW-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            data_o <= '0;
        end else begin
            done_o <= fire_i;
            if (fire_i) data_o <= bus_i;
        end
    end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            req_we_i,
    input  logic [AW-1:0]   req_addr_i,
    input  logic [DW-1:0]   req_wdata_i,
    input  logic [WS_W-1:0] wait_states_i,
    input  logic            auto_ack_i,
    output logic            req_ready_o,
    output logic            done_o,
    output logic [DW-1:0]   rdata_o,
    output logic            bclk_o,
    output logic [AW-1:0]   addr_o,
    output logic            bus_en_o,
    output logic            rw_o,
    output logic            cs_n_o,
    output logic            oe_n_o,
    output logic [DW-1:0]   data_o,
    output logic            data_oe_o,
    input  logic [DW-1:0]   data_i,
    input  logic            ta_n_i
);
    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } xfer_t;

    bus_state_e state_q, state_d;
    xfer_t      cur_q;
    logic       fall_half;
    logic       ack;
    logic       take;
    logic       ack_hit;

    ebc_phase_gen u_phase (
        .clk         (clk),
        .rst         (rst),
        .fall_half_o (fall_half)
    );

    ebc_ack_unit #(.WSW(WS_W)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .ta_n_i    (ta_n_i),
        .auto_en_i (auto_ack_i),
        .ws_i      (wait_states_i),
        .load_i    (state_q == ST_S1),
        .step_i    ((state_q == ST_S3) && !ack),
        .ack_o     (ack)
    );

    assign ack_hit = (state_q == ST_S3) && ack;

    ebc_rd_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .fire_i (ack_hit),
        .bus_i  (data_i),
        .done_o (done_o),
        .data_o (rdata_o)
    );

    assign req_ready_o = fall_half && ((state_q == ST_IDLE) || (state_q == ST_S5));
    assign take        = req_i && req_ready_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_S0;
            ST_S0:   state_d = ST_S1;
            ST_S1:   state_d = ST_S2;
            ST_S2:   state_d = ST_S3;
            ST_S3:   state_d = ack ? ST_S4 : ST_S2;
            ST_S4:   state_d = ST_S5;
            ST_S5:   state_d = take ? ST_S0 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) cur_q <= '{we: req_we_i, addr: req_addr_i, wdata: req_wdata_i};
        end
    end

    assign bclk_o    = ~fall_half;
    assign bus_en_o  = (state_q != ST_IDLE);
    assign addr_o    = cur_q.addr;
    assign rw_o      = ~(bus_en_o && cur_q.we);
    assign cs_n_o    = ~strobe_on(state_q);
    assign oe_n_o    = ~(strobe_on(state_q) && !cur_q.we);
    assign data_oe_o = cur_q.we && wdrive_on(state_q);
    assign data_o    = cur_q.wdata;
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready_o,
    input logic          done_o,
    input logic          bclk_o,
    input logic [AW-1:0] addr_o,
    input logic          bus_en_o,
    input logic          rw_o,
    input logic          cs_n_o,
    input logic          oe_n_o,
    input logic          data_oe_o
);
    p_ready_fall_half_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> !bclk_o);

    p_bus_start_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en_o) |-> bclk_o && cs_n_o);

    p_cs_fall_half_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> !bclk_o);

    p_cs_release_half_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> !bclk_o && bus_en_o);

    p_oe_inside_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !oe_n_o |-> !cs_n_o && rw_o);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_in_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !cs_n_o && bclk_o);

    p_no_early_drive_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> !data_oe_o);

    p_drive_in_write_r8: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> !cs_n_o && !rw_o && oe_n_o);

    p_addr_held_r9: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && $past(!cs_n_o)) |-> $stable(addr_o));

    p_bus_drop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_en_o) |-> bclk_o && $past(cs_n_o));
endmodule

bind ext_bus_ctrl ebc_checker #(.AW(AW)) u_ebc_checker (
    .clk         (clk),
    .rst         (rst),
    .req_ready_o (req_ready_o),
    .done_o      (done_o),
    .bclk_o      (bclk_o),
    .addr_o      (addr_o),
    .bus_en_o    (bus_en_o),
    .rw_o        (rw_o),
    .cs_n_o      (cs_n_o),
    .oe_n_o      (oe_n_o),
    .data_oe_o   (data_oe_o)
);

// File: tb/test_ext_bus_ctrl.sv
`timescale 1ns/1ps
module test_ext_bus_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_i = 1'b0, req_we_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_wdata_i = '0;
    logic [3:0]    wait_states_i = '0;
    logic          auto_ack_i = 1'b1;
    logic          req_ready_o, done_o, bclk_o, bus_en_o, rw_o, cs_n_o, oe_n_o, data_oe_o;
    logic [DW-1:0] rdata_o, data_o;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] data_i = '0;
    logic          ta_n_i = 1'b1;

    int checks = 0;
    int failures = 0;

    ext_bus_ctrl #(.AW(AW), .DW(DW)) i_ext_bus_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .req_we_i(req_we_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .wait_states_i(wait_states_i), .auto_ack_i(auto_ack_i),
        .req_ready_o(req_ready_o), .done_o(done_o), .rdata_o(rdata_o),
        .bclk_o(bclk_o), .addr_o(addr_o), .bus_en_o(bus_en_o), .rw_o(rw_o),
        .cs_n_o(cs_n_o), .oe_n_o(oe_n_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .data_i(data_i), .ta_n_i(ta_n_i)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected chip-select-low length when acknowledged by the pin.
    function automatic int ext_len(input int k);
        int s = (k + 1 > 3) ? k + 1 : 3;
        if (s % 2 == 0) s++;
        return s + 1;
    endfunction

    function automatic int auto_len(input int ws);
        return 4 + 2 * ws;
    endfunction

    // ext_k: -1 = auto mode, 0 = pin low beforehand, K>0 = pin low in K-th cs-low clock
    task automatic run_xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            input int ws, input int ext_k, input bit ta_lvl);
        int cs_len = 0, bus_len = 0, dones = 0, oe_bad = 0, drv_cnt = 0, drv_bad = 0;
        int exp_len;
        logic [DW-1:0] rd_seen = '0;
        logic [DW-1:0] bus_val = DW'($urandom);
        @(negedge clk);
        req_we_i = we; req_addr_i = a; req_wdata_i = wd; wait_states_i = 4'(ws);
        auto_ack_i = (ext_k < 0); data_i = bus_val;
        ta_n_i = (ext_k < 0) ? ta_lvl : (ext_k == 0) ? 1'b0 : 1'b1;
        req_i = 1'b1;
        while (!req_ready_o) @(negedge clk);
        check(bclk_o == 1'b0, "R2 ready in falling half", bclk_o, 0);
        @(negedge clk);
        req_i = 1'b0;
        check(bus_en_o && cs_n_o && bclk_o, "R2 S0 drive", {bus_en_o, cs_n_o, bclk_o}, 3'b111);
        check(addr_o == a, "R2 address", addr_o, a);
        check(rw_o == !we, "R2 rw", rw_o, !we);
        for (int i = 0; i < 200 && bus_en_o; i++) begin
            bus_len++;
            if (!cs_n_o) begin
                cs_len++;
                if (ext_k > 0 && cs_len == ext_k) ta_n_i = 1'b0;
                if (we) begin
                    if (cs_len == 1 && data_oe_o) drv_bad++;
                    if (cs_len > 1 && !(data_oe_o && data_o == wd)) drv_bad++;
                    if (data_oe_o) drv_cnt++;
                    if (!oe_n_o) oe_bad++;
                end else if (oe_n_o) oe_bad++;
            end else if (data_oe_o || !oe_n_o) begin
                drv_bad++;
            end
            if (done_o) begin
                dones++;
                rd_seen = rdata_o;
                if (cs_n_o) oe_bad++;
                if (ext_k > 0) ta_n_i = 1'b1;
            end
            @(negedge clk);
        end
        ta_n_i = 1'b1;
        exp_len = (ext_k < 0) ? auto_len(ws) : (ext_k == 0) ? 4 : ext_len(ext_k);
        if (ext_k < 0) begin
            check(cs_len == exp_len, ta_lvl ? "R4 auto length" : "R5 auto length ta ignored",
                  cs_len, exp_len);
        end else begin
            check(cs_len == exp_len, "R6 external ack length", cs_len, exp_len);
        end
        check(bus_len == cs_len + 2, "R10 bus drive span", bus_len, cs_len + 2);
        check(oe_bad == 0, "R3 oe/cs relation", oe_bad, 0);
        check(dones == 1, "R7 done pulse count", dones, 1);
        if (we) begin
            check(drv_bad == 0 && drv_cnt == cs_len - 1, "R8 write data drive", drv_cnt, cs_len - 1);
        end else begin
            check(rd_seen == bus_val, "R7 read data", rd_seen, bus_val);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(cs_n_o && oe_n_o && !bus_en_o && !data_oe_o && !done_o && rw_o,
              "R1 reset outputs", {cs_n_o, oe_n_o, bus_en_o, data_oe_o, done_o, rw_o}, 6'b110001);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n_o && !bus_en_o && !req_ready_o == bclk_o, "R1 after reset", cs_n_o, 1);

        // directed corners
        run_xfer(1'b0, 16'h1234, 16'h0, 0, -1, 1'b1);
        run_xfer(1'b0, 16'h4321, 16'h0, 15, -1, 1'b1);
        run_xfer(1'b0, 16'h0F0F, 16'h0, 3, -1, 1'b0);
        run_xfer(1'b1, 16'hBEEF, 16'hCAFE, 0, -1, 1'b1);
        run_xfer(1'b1, 16'hAAAA, 16'h5555, 2, 0, 1'b1);
        run_xfer(1'b0, 16'h0101, 16'h0, 0, 1, 1'b1);
        run_xfer(1'b0, 16'h0202, 16'h0, 0, 4, 1'b1);
        run_xfer(1'b0, 16'h0303, 16'h0, 0, 5, 1'b1);

        // R9 back-to-back restart from S5
        @(negedge clk);
        req_we_i = 1'b0; req_addr_i = 16'h7777; auto_ack_i = 1'b1; wait_states_i = 4'd1;
        req_i = 1'b1;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_i = 1'b0;
        for (int i = 0; i < 50 && !done_o; i++) @(negedge clk);
        req_we_i = 1'b1; req_addr_i = 16'h8888; req_wdata_i = 16'h1111; req_i = 1'b1;
        @(negedge clk);
        check(req_ready_o && bus_en_o && cs_n_o, "R9 ready in S5", req_ready_o, 1);
        @(negedge clk);
        req_i = 1'b0;
        check(bus_en_o && addr_o == 16'h8888 && !rw_o, "R9 restart address", addr_o, 16'h8888);
        for (int i = 0; i < 50 && bus_en_o; i++) @(negedge clk);
        check(!bus_en_o, "R10 idle after chain", bus_en_o, 0);

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int mode = $urandom_range(0, 7);
            run_xfer(1'($urandom), AW'($urandom), DW'($urandom), $urandom_range(0, 5),
                     (mode < 3) ? -1 : mode - 3, 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule